// File: doc/BRIEF.md
# Dual-Issue Pairing and Hazard Checker

This block sits at the issue stage of an in-order pipeline that can start two instructions per cycle. Each cycle it looks at the two oldest queued instructions. Slot 0 holds the older one and slot 1 the younger. For each cycle the block decides one of three outcomes: both instructions start, only the older one starts, or nothing starts. Each instruction arrives as a packed descriptor. The descriptor gives the instruction's class, its destination, two source operands, an address-base operand, a flag-setting bit and a conditional bit.

Two sets of checks make the decision. Pairing checks compare the two candidates with each other. The rules forbid two branches together, two memory accesses together, and a common destination. They also forbid a read by the younger instruction of a value the older one produces. Two exceptions apply. A store may take its data from its partner, because store data is consumed late. A conditional branch may sit beside a flag setter, because the branch resolves a cycle later.

A short history of recently issued instructions enforces the timing rules against earlier cycles. These are the load-use bubble, the extra cycle before a freshly written register can act as an address base, and the window in which a shift operand must not have been written. The issue decision is combinational from the current descriptors and the registered history. The queue logic can therefore pop the consumed entries in the same cycle.

Top module: `pair_issue_ctl`

## Requirements
- R1: Slot 0 issues exactly when it is valid, reset and flush are low, and none of the history rules R8, R9 or R10 blocks it. During reset neither slot issues.
- R2: Slot 1 never issues in a cycle where slot 0 does not issue. If slot 0 issues, slot 1 issues whenever it is valid and none of R3 to R10 blocks it.
- R3: Two instructions of class branch never issue in the same cycle.
- R4: Two memory instructions (class load or store) never issue in the same cycle.
- R5: Two instructions that both write the same destination register never issue in the same cycle.
- R6: Slot 1 does not issue when it reads the register that slot 0 writes. Reads are src1, the address base, and src0 for any class except store. The src0 of a store is its data operand, so a store may pair with the writer of its data.
- R7: A conditional slot 1 instruction does not issue beside a flag-setting slot 0 instruction, unless slot 1 is a branch.
- R8: An instruction that reads (per R6) the destination of a load issued in the previous cycle stalls. Two cycles after the load, it may issue.
- R9: An instruction whose address base was written by any instruction issued in the previous cycle stalls. Two cycles after the write, it may issue.
- R10: A shift whose src0 equals the destination of one of the last three issued instructions stalls, if that writer issued within the last three cycles.
- R11: While flush is high nothing issues. The history is emptied at that edge, so no later stall is caused by instructions issued before the flush.
- R12: The descriptor is 29 bits wide. Bits 28:26 hold the class: 0 ALU, 1 shift, 2 load, 3 store, 4 branch. Bit 25 enables the destination and bits 24:20 give it. Bit 19 enables src0 and bits 18:14 give it. Bit 13 enables src1 and bits 12:8 give it. Bit 7 enables the base and bits 6:2 give it. Bit 1 means the instruction sets flags, and bit 0 means it is conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pipeline flush: blocks issue and empties the history |
| s0_vld | input | 1 | Older candidate present |
| s0_desc | input | 29 | Older candidate descriptor (R12 layout) |
| s1_vld | input | 1 | Younger candidate present |
| s1_desc | input | 29 | Younger candidate descriptor (R12 layout) |
| issue0 | output | 1 | Older candidate issues this cycle |
| issue1 | output | 1 | Younger candidate issues this cycle |

## Verification
The bench goes after the two pairing exceptions. A design that drops the store-data exemption would stall every store that follows its data producer. One that lets any conditional instruction pass a flag setter would read stale flags.

The bench times load-use and address-base stalls to the exact cycle. An off-by-one history age would either issue one cycle early or add a second bubble.

For shifts, the bench separates "pushed out of the three-entry history" from "aged beyond three cycles". A design that ignores either rule would deadlock or skip a needed stall.

Flush is checked to empty the history. A design that keeps stale entries would stall a shift after the flush.

// File: rtl/issue_pkg.sv
package issue_pkg;

  parameter int REG_W = 5;
  localparam int DESC_W = 4 * REG_W + 9;
  localparam int AGE_W = 3;

  typedef enum logic [2:0] {
    CL_ALU    = 3'd0,
    CL_SHIFT  = 3'd1,
    CL_LOAD   = 3'd2,
    CL_STORE  = 3'd3,
    CL_BRANCH = 3'd4
  } iclass_e;

  typedef struct packed {
    iclass_e          cls;
    logic             dst_en;
    logic [REG_W-1:0] dst;
    logic             src0_en;
    logic [REG_W-1:0] src0;
    logic             src1_en;
    logic [REG_W-1:0] src1;
    logic             base_en;
    logic [REG_W-1:0] base;
    logic             setf;
    logic             cond;
  } idesc_t;

  typedef struct packed {
    logic             vld;
    logic             wr;
    logic             ld;
    logic [REG_W-1:0] dst;
    logic [AGE_W-1:0] age;
  } sb_ent_t;

  // Early-read test: store data (src0 of a store) is consumed late and is not counted.
  function automatic logic reads_reg(input logic is_store,
                                     input logic s0e, input logic [REG_W-1:0] s0,
                                     input logic s1e, input logic [REG_W-1:0] s1,
                                     input logic be,  input logic [REG_W-1:0] b,
                                     input logic [REG_W-1:0] r);
    return (s1e && s1 == r) || (be && b == r) || (!is_store && s0e && s0 == r);
  endfunction

endpackage

// File: rtl/writer_scoreboard.sv
module writer_scoreboard
  import issue_pkg::*;
#(
  parameter int HIST = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 push0,
  input  logic                 push1,
  input  logic                 wr0,
  input  logic                 ld0,
  input  logic [REG_W-1:0]     dst0,
  input  logic                 wr1,
  input  logic                 ld1,
  input  logic [REG_W-1:0]     dst1,
  output sb_ent_t [HIST-1:0]   ent
);

  function automatic sb_ent_t age_up(input sb_ent_t e);
    sb_ent_t r;
    r = e;
    if (e.vld && e.age != '1) r.age = e.age + AGE_W'(1);
    return r;
  endfunction

  sb_ent_t        fresh0, fresh1;
  logic [HIST-1:0] vld_vec;

  assign fresh0 = '{vld: 1'b1, wr: wr0, ld: ld0, dst: dst0, age: AGE_W'(1)};
  assign fresh1 = '{vld: 1'b1, wr: wr1, ld: ld1, dst: dst1, age: AGE_W'(1)};

  // Entry 0 is the newest; a push of n instructions moves older entries down by n.
  for (genvar g = 0; g < HIST; g++) begin : g_ent
    sb_ent_t ent_r, from1, from2;

    if (g >= 1) begin : g_f1
      assign from1 = age_up(ent[g-1]);
    end else begin : g_f1n
      assign from1 = fresh0;
    end

    if (g >= 2) begin : g_f2
      assign from2 = age_up(ent[g-2]);
    end else if (g == 1) begin : g_f2a
      assign from2 = fresh0;
    end else begin : g_f2b
      assign from2 = fresh1;
    end

    always_ff @(posedge clk) begin
      if (rst || flush)        ent_r <= '0;
      else if (push0 && push1) ent_r <= from2;
      else if (push0)          ent_r <= from1;
      else                     ent_r <= age_up(ent_r);
    end

    assign ent[g]     = ent_r;
    assign vld_vec[g] = ent_r.vld;
  end

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_vec == '0));

  a_r10_newest_age: assert property (@(posedge clk) disable iff (rst)
    (push0 && !flush) |=> (ent[0].vld && ent[0].age == AGE_W'(1)));

  a_r2_push_order: assert property (@(posedge clk) disable iff (rst)
    push1 |-> push0);

endmodule

// File: rtl/hazard_scan.sv
module hazard_scan
  import issue_pkg::*;
#(
  parameter int HIST = 3
) (
  input  logic               is_shift,
  input  logic               is_store,
  input  logic               src0_en,
  input  logic [REG_W-1:0]   src0,
  input  logic               src1_en,
  input  logic [REG_W-1:0]   src1,
  input  logic               base_en,
  input  logic [REG_W-1:0]   base,
  input  sb_ent_t [HIST-1:0] ent,
  output logic               haz_lu,
  output logic               haz_ag,
  output logic               haz_sh
);

  logic [HIST-1:0] lu, ag, sh;

  for (genvar g = 0; g < HIST; g++) begin : g_cmp
    logic live, last_cyc;
    assign live     = ent[g].vld && ent[g].wr;
    assign last_cyc = ent[g].age == AGE_W'(1);
    assign lu[g] = live && ent[g].ld && last_cyc &&
                   reads_reg(is_store, src0_en, src0, src1_en, src1, base_en, base, ent[g].dst);
    assign ag[g] = live && last_cyc && base_en && base == ent[g].dst;
    assign sh[g] = live && is_shift && src0_en && src0 == ent[g].dst &&
                   ent[g].age <= AGE_W'(HIST);
  end

  assign haz_lu = |lu;
  assign haz_ag = |ag;
  assign haz_sh = |sh;

endmodule

// File: rtl/pair_rules.sv
module pair_rules
  import issue_pkg::*;
(
  input  iclass_e          a_cls,
  input  logic             a_dst_en,
  input  logic [REG_W-1:0] a_dst,
  input  logic             a_setf,
  input  iclass_e          b_cls,
  input  logic             b_dst_en,
  input  logic [REG_W-1:0] b_dst,
  input  logic             b_cond,
  input  logic             b_reads_a,
  output logic             conflict
);

  logic two_br, two_mem, same_dst, raw, flag_dep, a_mem, b_mem;

  always_comb begin
    a_mem    = (a_cls == CL_LOAD) || (a_cls == CL_STORE);
    b_mem    = (b_cls == CL_LOAD) || (b_cls == CL_STORE);
    two_br   = (a_cls == CL_BRANCH) && (b_cls == CL_BRANCH);
    two_mem  = a_mem && b_mem;
    same_dst = a_dst_en && b_dst_en && (a_dst == b_dst);
    raw      = a_dst_en && b_reads_a;
    flag_dep = a_setf && b_cond && (b_cls != CL_BRANCH);
    conflict = two_br || two_mem || same_dst || raw || flag_dep;
  end

endmodule

// File: rtl/pair_issue_ctl.sv
module pair_issue_ctl
  import issue_pkg::*;
#(
  parameter int HIST = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              s0_vld,
  input  logic [DESC_W-1:0] s0_desc,
  input  logic              s1_vld,
  input  logic [DESC_W-1:0] s1_desc,
  output logic              issue0,
  output logic              issue1
);

  idesc_t             d0, d1;
  sb_ent_t [HIST-1:0] hist;
  logic               lu0, ag0, sh0, lu1, ag1, sh1;
  logic               pair_bad, b_reads_a;
  logic               unused_bits;

  assign d0 = idesc_t'(s0_desc);
  assign d1 = idesc_t'(s1_desc);
  assign unused_bits = d0.cond ^ d1.setf;

  assign b_reads_a = reads_reg(d1.cls == CL_STORE, d1.src0_en, d1.src0, d1.src1_en, d1.src1,
                               d1.base_en, d1.base, d0.dst);

  hazard_scan #(.HIST(HIST)) u_haz0 (
    .is_shift(d0.cls == CL_SHIFT), .is_store(d0.cls == CL_STORE),
    .src0_en(d0.src0_en), .src0(d0.src0), .src1_en(d0.src1_en), .src1(d0.src1),
    .base_en(d0.base_en), .base(d0.base), .ent(hist),
    .haz_lu(lu0), .haz_ag(ag0), .haz_sh(sh0)
  );

  hazard_scan #(.HIST(HIST)) u_haz1 (
    .is_shift(d1.cls == CL_SHIFT), .is_store(d1.cls == CL_STORE),
    .src0_en(d1.src0_en), .src0(d1.src0), .src1_en(d1.src1_en), .src1(d1.src1),
    .base_en(d1.base_en), .base(d1.base), .ent(hist),
    .haz_lu(lu1), .haz_ag(ag1), .haz_sh(sh1)
  );

  pair_rules u_pair (
    .a_cls(d0.cls), .a_dst_en(d0.dst_en), .a_dst(d0.dst), .a_setf(d0.setf),
    .b_cls(d1.cls), .b_dst_en(d1.dst_en), .b_dst(d1.dst), .b_cond(d1.cond),
    .b_reads_a(b_reads_a), .conflict(pair_bad)
  );

  assign issue0 = !rst && !flush && s0_vld && !(lu0 || ag0 || sh0);
  assign issue1 = issue0 && s1_vld && !(lu1 || ag1 || sh1) && !pair_bad;

  writer_scoreboard #(.HIST(HIST)) u_sb (
    .clk(clk), .rst(rst), .flush(flush),
    .push0(issue0), .push1(issue1),
    .wr0(d0.dst_en), .ld0(d0.cls == CL_LOAD), .dst0(d0.dst),
    .wr1(d1.dst_en), .ld1(d1.cls == CL_LOAD), .dst1(d1.dst),
    .ent(hist)
  );

  a_r2_in_order: assert property (@(posedge clk) disable iff (rst)
    issue1 |-> issue0);

  a_r3_one_branch: assert property (@(posedge clk) disable iff (rst)
    (issue0 && issue1) |-> !(d0.cls == CL_BRANCH && d1.cls == CL_BRANCH));

  a_r4_one_mem: assert property (@(posedge clk) disable iff (rst)
    (issue0 && issue1) |-> !((d0.cls == CL_LOAD || d0.cls == CL_STORE) &&
                             (d1.cls == CL_LOAD || d1.cls == CL_STORE)));

  a_r5_distinct_dst: assert property (@(posedge clk) disable iff (rst)
    (issue0 && issue1 && d0.dst_en && d1.dst_en) |-> (d0.dst != d1.dst));

  a_r8_load_use: assert property (@(posedge clk) disable iff (rst)
    ($past(issue0 && !issue1 && d0.cls == CL_LOAD && d0.dst_en) && issue0) |->
      !reads_reg(d0.cls == CL_STORE, d0.src0_en, d0.src0, d0.src1_en, d0.src1,
                 d0.base_en, d0.base, $past(d0.dst)));

  a_r11_flush_quiet: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!issue0 && !issue1));

endmodule

// File: tb/sim_pair_issue_ctl.sv
module sim_pair_issue_ctl;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, flush, s0_vld, s1_vld;
  logic [28:0] s0_desc, s1_desc;
  logic        issue0, issue1;

  int n_chk = 0;
  int n_bad = 0;

  bit          mv[3], mw[3], ml[3];
  logic [4:0]  md[3];
  int          ma[3];

  always #(PERIOD/2) clk = ~clk;

  pair_issue_ctl u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .s0_vld(s0_vld), .s0_desc(s0_desc), .s1_vld(s1_vld), .s1_desc(s1_desc),
    .issue0(issue0), .issue1(issue1)
  );

  // R12 layout: {class[2:0], dst_en, dst[4:0], src0_en, src0, src1_en, src1, base_en, base, setf, cond}
  function automatic logic [28:0] mk(int c, bit de, int dr, bit e0, int r0, bit e1, int r1,
                                     bit be, int rb, bit sf, bit cd);
    return {3'(c), de, 5'(dr), e0, 5'(r0), e1, 5'(r1), be, 5'(rb), sf, cd};
  endfunction

  function automatic bit rd(logic [28:0] d, logic [4:0] r);
    return (d[13] && d[12:8] == r) || (d[7] && d[6:2] == r) ||
           (d[19] && d[18:14] == r && d[28:26] != 3'd3);
  endfunction

  function automatic string sb_tag(logic [28:0] d);
    for (int i = 0; i < 3; i++) begin
      if (mv[i] && mw[i]) begin
        if (ml[i] && ma[i] == 1 && rd(d, md[i])) return "R8";
        if (ma[i] == 1 && d[7] && d[6:2] == md[i]) return "R9";
        if (d[28:26] == 3'd1 && d[19] && d[18:14] == md[i] && ma[i] <= 3) return "R10";
      end
    end
    return "";
  endfunction

  function automatic string pair_tag(logic [28:0] a, logic [28:0] b);
    if (a[28:26] == 3'd4 && b[28:26] == 3'd4) return "R3";
    if ((a[28:26] == 3'd2 || a[28:26] == 3'd3) && (b[28:26] == 3'd2 || b[28:26] == 3'd3)) return "R4";
    if (a[25] && b[25] && a[24:20] == b[24:20]) return "R5";
    if (a[25] && rd(b, a[24:20])) return "R6";
    if (b[0] && a[1] && b[28:26] != 3'd4) return "R7";
    return "";
  endfunction

  task automatic put(int i, logic [28:0] d);
    mv[i] = 1'b1; mw[i] = d[25]; ml[i] = (d[28:26] == 3'd2); md[i] = d[24:20]; ma[i] = 1;
  endtask

  task automatic model_step(bit clr, bit e0, bit e1, logic [28:0] d0, logic [28:0] d1);
    if (clr) begin
      for (int i = 0; i < 3; i++) mv[i] = 1'b0;
      return;
    end
    for (int i = 0; i < 3; i++) if (mv[i] && ma[i] < 7) ma[i]++;
    if (e0 && e1) begin
      mv[2] = mv[0]; mw[2] = mw[0]; ml[2] = ml[0]; md[2] = md[0]; ma[2] = ma[0];
      put(1, d0); put(0, d1);
    end else if (e0) begin
      mv[2] = mv[1]; mw[2] = mw[1]; ml[2] = ml[1]; md[2] = md[1]; ma[2] = ma[1];
      mv[1] = mv[0]; mw[1] = mw[0]; ml[1] = ml[0]; md[1] = md[0]; ma[1] = ma[0];
      put(0, d0);
    end
  endtask

  task automatic check(logic got, bit exp, string req, string lbl);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (%s): got %0b expected %0b", req, lbl, got, exp);
    end
  endtask

  task automatic cyc(bit r, bit f, bit v0, logic [28:0] d0, bit v1, logic [28:0] d1, string lbl);
    bit e0, e1;
    string t0, t1, p;
    @(negedge clk);
    rst = r; flush = f; s0_vld = v0; s0_desc = d0; s1_vld = v1; s1_desc = d1;
    #(PERIOD/4);
    e0 = !r && !f && v0 && sb_tag(d0) == "";
    t0 = r ? "R1" : f ? "R11" : (sb_tag(d0) != "") ? sb_tag(d0) : "R1";
    check(issue0, e0, t0, lbl);
    p  = pair_tag(d0, d1);
    e1 = e0 && v1 && sb_tag(d1) == "" && p == "";
    t1 = !e0 ? "R2" : (p != "") ? p : (sb_tag(d1) != "") ? sb_tag(d1) : "R1";
    check(issue1, e1, t1, lbl);
    model_step(r || f, e0, e1, d0, d1);
  endtask

  task automatic clear();
    cyc(0, 1, 0, '0, 0, '0, "R11 clear");
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [28:0] x, y;
    void'($urandom(32'h5eed_1a2b));
    for (int i = 0; i < 3; i++) begin mv[i] = 0; mw[i] = 0; ml[i] = 0; md[i] = '0; ma[i] = 0; end
    rst = 1'b1; flush = 1'b0; s0_vld = 0; s1_vld = 0; s0_desc = '0; s1_desc = '0;

    // R1 reset: nothing issues
    cyc(1, 0, 1, mk(0,1,1,0,0,0,0,0,0,0,0), 1, mk(0,1,2,0,0,0,0,0,0,0,0), "R1 reset");
    cyc(1, 0, 1, mk(0,1,1,0,0,0,0,0,0,0,0), 0, '0, "R1 reset");
    // R12 plain independent pair
    cyc(0, 0, 1, mk(0,1,1,1,3,0,0,0,0,0,0), 1, mk(1,1,2,1,4,0,0,0,0,0,0), "R12 independent pair");
    clear();
    cyc(0, 0, 1, mk(4,0,0,0,0,0,0,0,0,0,0), 1, mk(4,0,0,0,0,0,0,0,0,0,1), "R3 two branches");
    clear();
    cyc(0, 0, 1, mk(2,1,3,0,0,0,0,1,0,0,0), 1, mk(3,0,0,1,2,0,0,1,1,0,0), "R4 load+store");
    clear();
    cyc(0, 0, 1, mk(0,1,4,0,0,0,0,0,0,0,0), 1, mk(1,1,4,0,0,0,0,0,0,0,0), "R5 same dst");
    clear();
    cyc(0, 0, 1, mk(0,1,5,0,0,0,0,0,0,0,0), 1, mk(0,1,9,0,0,1,5,0,0,0,0), "R6 raw blocks");
    clear();
    cyc(0, 0, 1, mk(0,1,6,0,0,0,0,0,0,0,0), 1, mk(3,0,0,1,6,0,0,1,7,0,0), "R6 store data pairs");
    clear();
    cyc(0, 0, 1, mk(0,1,6,0,0,0,0,0,0,0,0), 1, mk(3,0,0,1,1,0,0,1,6,0,0), "R6 store base blocks");
    clear();
    cyc(0, 0, 1, mk(0,1,1,0,0,0,0,0,0,1,0), 1, mk(0,1,2,0,0,0,0,0,0,0,1), "R7 cond alu blocks");
    clear();
    cyc(0, 0, 1, mk(0,1,1,0,0,0,0,0,0,1,0), 1, mk(4,0,0,0,0,0,0,0,0,0,1), "R7 cond branch pairs");
    clear();
    cyc(0, 0, 1, mk(2,1,8,0,0,0,0,1,0,0,0), 0, '0, "R8 load");
    cyc(0, 0, 1, mk(0,1,9,0,0,1,8,0,0,0,0), 0, '0, "R8 bubble");
    cyc(0, 0, 1, mk(0,1,9,0,0,1,8,0,0,0,0), 0, '0, "R8 after bubble");
    clear();
    cyc(0, 0, 1, mk(2,1,8,0,0,0,0,1,0,0,0), 0, '0, "R8 load");
    cyc(0, 0, 1, mk(3,0,0,1,8,0,0,1,1,0,0), 0, '0, "R8 store data exempt");
    clear();
    cyc(0, 0, 1, mk(0,1,9,0,0,0,0,0,0,0,0), 0, '0, "R9 write");
    cyc(0, 0, 1, mk(2,1,2,0,0,0,0,1,9,0,0), 0, '0, "R9 base stall");
    cyc(0, 0, 1, mk(2,1,2,0,0,0,0,1,9,0,0), 0, '0, "R9 base ok");
    clear();
    cyc(0, 0, 1, mk(0,1,10,0,0,0,0,0,0,0,0), 0, '0, "R10 write");
    for (int k = 0; k < 4; k++) cyc(0, 0, 1, mk(1,1,3,1,10,0,0,0,0,0,0), 0, '0, "R10 age window");
    clear();
    cyc(0, 0, 1, mk(0,1,10,0,0,0,0,0,0,0,0), 1, mk(0,1,11,0,0,0,0,0,0,0,0), "R10 fill");
    cyc(0, 0, 1, mk(0,1,12,0,0,0,0,0,0,0,0), 1, mk(0,1,13,0,0,0,0,0,0,0,0), "R10 fill");
    cyc(0, 0, 1, mk(1,1,3,1,10,0,0,0,0,0,0), 0, '0, "R10 pushed out");
    cyc(0, 0, 1, mk(1,1,4,1,13,0,0,0,0,0,0), 0, '0, "R10 in window");
    clear();
    cyc(0, 0, 1, mk(0,1,14,0,0,0,0,0,0,0,0), 0, '0, "R11 write");
    cyc(0, 1, 1, mk(1,1,3,1,14,0,0,0,0,0,0), 1, mk(0,1,2,0,0,0,0,0,0,0,0), "R11 flush quiet");
    cyc(0, 0, 1, mk(1,1,3,1,14,0,0,0,0,0,0), 0, '0, "R11 history emptied");

    // Constrained random: small register range to provoke hazards.
    for (int k = 0; k < 4000; k++) begin
      x = mk($urandom % 5, $urandom % 2, $urandom % 4, $urandom % 2, $urandom % 4,
             $urandom % 2, $urandom % 4, $urandom % 2, $urandom % 4, $urandom % 2, $urandom % 2);
      y = mk($urandom % 5, $urandom % 2, $urandom % 4, $urandom % 2, $urandom % 4,
             $urandom % 2, $urandom % 4, $urandom % 2, $urandom % 4, $urandom % 2, $urandom % 2);
      cyc(($urandom % 200) == 0, ($urandom % 32) == 0, ($urandom % 8) != 0, x,
          ($urandom % 4) != 0, y, "random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule